// File: doc/BRIEF.md
# Local Bus Arbiter with Release Control

This block decides which of five requesters owns a shared local bus. The requesters are an external master that asks for the bus with a request/acknowledge handshake, a DMA engine in burst mode, the CPU, the DMA engine in single-transfer mode, and a PCI-side controller. Ownership is shown as a one-hot grant vector. When no one asks for the bus, the CPU owns it.

Ownership moves only at safe points. A safe point is either the moment the current owner stops requesting, or a transfer boundary reported on `xfer_done_i`. A small control register holds three settings:
- whether external requests are accepted;
- whether an active DMA burst locks the bus until the burst ends;
- whether the write-enable and read strobes stay driven while the bus is handed to the external master.

A slave-boot strap forces external requests to be accepted, whatever the enable setting holds.

Top module: `lbus_arbiter`

## Requirements
- R1: After reset `grant_o` is 5'b00100 (CPU). At every cycle exactly one grant bit is set. When no request is present, ownership returns to the CPU (bit 2) at the next clock edge.
- R2: Grant bit positions are: 0 external, 1 DMA burst, 2 CPU, 3 DMA single, 4 PCI. When ownership may move, the grant goes to the lowest-numbered active request.
- R3: Ownership changes only when the owner's own request is low, or when `xfer_done_i` is high. At such a boundary a higher-priority request takes the bus from an owner that is still requesting.
- R4: Control bit 1 is the burst lock. While it is 1 and the DMA burst owner keeps `dma_burst_req_i` high, the grant stays on the burst even at transfer boundaries. While it is 0, a higher-priority request takes the bus at the next boundary.
- R5: Control bit 0 is the external enable. While it is 0 and `slave_boot_i` is low, `ext_req_i` is ignored: grant bit 0 never sets, and an existing external ownership ends at the next edge.
- R6: While `slave_boot_i` is high, `ext_req_i` is accepted even with the external enable at 0.
- R7: `ext_ack_o` rises one edge after grant bit 0 rises. It falls one edge after `ext_req_i` (or its acceptance) drops. `bus_released_o` follows `ext_ack_o`.
- R8: Control bit 2 is the strobe drive. While the bus is released and bit 2 is 0, `we_oe_o` and `rd_oe_o` are 0. In every other state they are 1.
- R9: The control register resets to 0. It is written with `cfg_we_i` and updates on the next edge. `cfg_rdata_o` returns bits 2..0, and all higher bits read 0 regardless of the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| slave_boot_i | input | 1 | Slave-boot strap, forces acceptance of external requests |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | DATA_W | Control register write data |
| cfg_rdata_o | output | DATA_W | Control register read data |
| ext_req_i | input | 1 | External master bus request |
| ext_ack_o | output | 1 | External master bus acknowledge |
| dma_burst_req_i | input | 1 | DMA burst-mode request |
| cpu_req_i | input | 1 | CPU request |
| dma_req_i | input | 1 | DMA single-transfer request |
| pci_req_i | input | 1 | PCI-side controller request |
| xfer_done_i | input | 1 | Current owner is at a transfer boundary |
| grant_o | output | 5 | One-hot grant vector |
| bus_released_o | output | 1 | Bus handed to external master |
| we_oe_o | output | 1 | Write-enable strobe output enable |
| rd_oe_o | output | 1 | Read strobe output enable |

## Verification
Results arrive at three different times:
- `grant_o` and `cfg_rdata_o` show the inputs sampled at one rising edge right after that edge.
- `ext_ack_o` and `bus_released_o` trail the grant by one more edge.
- The strobe enables follow the acknowledge and the register in the same cycle.

The bench holds a reference state that advances exactly once per rising edge, using the inputs driven at the preceding falling edge. It compares every output at the next falling edge, so each check sees the result that one edge produced. Directed sequences cover the priority chain, burst lock with the lock bit set and clear, the strap override and both strobe settings. Seeded random traffic follows.

// File: rtl/lbus_arb_pkg.sv
package lbus_arb_pkg;
  localparam int unsigned N_REQ     = 5;
  localparam int unsigned IDX_EXT   = 0;
  localparam int unsigned IDX_BURST = 1;
  localparam int unsigned IDX_CPU   = 2;
  localparam int unsigned IDX_DMA   = 3;
  localparam int unsigned IDX_PCI   = 4;
  localparam int unsigned CFG_W     = 3;

  typedef struct packed {
    logic strobe_drive;  // bit 2
    logic burst_lock;    // bit 1
    logic ext_en;        // bit 0
  } arb_cfg_t;
endpackage

// File: rtl/lbus_cfg_reg.sv
module lbus_cfg_reg
  import lbus_arb_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output arb_cfg_t          cfg_o
);
  localparam int unsigned PAD_W = DATA_W - CFG_W;

  arb_cfg_t cfg_q;
  logic     unused_hi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (we_i) cfg_q <= arb_cfg_t'(wdata_i[CFG_W-1:0]);
  end

  // reserved bits: writes dropped, reads zero
  assign unused_hi = ^wdata_i[DATA_W-1:CFG_W];
  assign rdata_o   = {{PAD_W{1'b0}}, cfg_q};
  assign cfg_o     = cfg_q;
endmodule

// File: rtl/lbus_prio_sel.sv
module lbus_prio_sel #(
  parameter int unsigned N           = 5,
  parameter int unsigned DEFAULT_IDX = 2
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] win_o
);
  localparam logic [N-1:0] DEFAULT_VEC = N'(1) << DEFAULT_IDX;

  logic [N:0]   seen;
  logic [N-1:0] win_raw;

  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign win_raw[i]  = req_i[i] & ~seen[i];
    assign seen[i+1]   = seen[i] | req_i[i];
  end

  assign win_o = seen[N] ? win_raw : DEFAULT_VEC;
endmodule

// File: rtl/lbus_ext_hs.sv
module lbus_ext_hs (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic owner_ext_i,
  input  logic req_eff_i,
  output logic ack_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_o <= 1'b0;
    else         ack_o <= owner_ext_i & req_eff_i;
  end
endmodule

// File: rtl/lbus_arbiter.sv
module lbus_arbiter
  import lbus_arb_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slave_boot_i,
  input  logic              cfg_we_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [DATA_W-1:0] cfg_rdata_o,
  input  logic              ext_req_i,
  output logic              ext_ack_o,
  input  logic              dma_burst_req_i,
  input  logic              cpu_req_i,
  input  logic              dma_req_i,
  input  logic              pci_req_i,
  input  logic              xfer_done_i,
  output logic [N_REQ-1:0]  grant_o,
  output logic              bus_released_o,
  output logic              we_oe_o,
  output logic              rd_oe_o
);
  localparam logic [N_REQ-1:0] RESET_OWNER = N_REQ'(1) << IDX_CPU;

  arb_cfg_t         cfg;
  logic             ext_eff;
  logic [N_REQ-1:0] req_vec;
  logic [N_REQ-1:0] win;
  logic [N_REQ-1:0] owner_q;
  logic             owner_req;
  logic             lock_hold;
  logic             may_switch;
  logic             ack;

  lbus_cfg_reg #(.DATA_W(DATA_W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .cfg_o   (cfg)
  );

  assign ext_eff = ext_req_i & (cfg.ext_en | slave_boot_i);

  always_comb begin
    req_vec            = '0;
    req_vec[IDX_EXT]   = ext_eff;
    req_vec[IDX_BURST] = dma_burst_req_i;
    req_vec[IDX_CPU]   = cpu_req_i;
    req_vec[IDX_DMA]   = dma_req_i;
    req_vec[IDX_PCI]   = pci_req_i;
  end

  lbus_prio_sel #(.N(N_REQ), .DEFAULT_IDX(IDX_CPU)) u_sel (
    .req_i (req_vec),
    .win_o (win)
  );

  assign owner_req  = |(owner_q & req_vec);
  // burst lock: the burst owner keeps the bus across boundaries
  assign lock_hold  = cfg.burst_lock & owner_q[IDX_BURST] & dma_burst_req_i;
  assign may_switch = ~owner_req | (xfer_done_i & ~lock_hold);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         owner_q <= RESET_OWNER;
    else if (may_switch) owner_q <= win;
  end

  lbus_ext_hs u_hs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .owner_ext_i (owner_q[IDX_EXT]),
    .req_eff_i   (ext_eff),
    .ack_o       (ack)
  );

  assign grant_o        = owner_q;
  assign ext_ack_o      = ack;
  assign bus_released_o = ack;
  assign we_oe_o        = ~ack | cfg.strobe_drive;
  assign rd_oe_o        = ~ack | cfg.strobe_drive;
endmodule

// File: rtl/lbus_arbiter_chk.sv
module lbus_arbiter_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              slave_boot_i,
  input logic [DATA_W-1:0] cfg_rdata_o,
  input logic              ext_req_i,
  input logic              ext_ack_o,
  input logic              dma_burst_req_i,
  input logic              cpu_req_i,
  input logic              dma_req_i,
  input logic              pci_req_i,
  input logic [4:0]        grant_o,
  input logic              bus_released_o,
  input logic              we_oe_o,
  input logic              rd_oe_o
);
  assert_grant_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(grant_o) == 1);

  assert_idle_to_cpu_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_req_i && !dma_burst_req_i && !cpu_req_i && !dma_req_i && !pci_req_i)
    |=> grant_o[2]);

  assert_burst_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rdata_o[1] && grant_o[1] && dma_burst_req_i) |=> grant_o[1]);

  assert_ext_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_rdata_o[0] && !slave_boot_i) |=> !grant_o[0]);

  assert_ack_after_grant_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ext_ack_o) |-> $past(grant_o[0]));

  assert_ack_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ext_req_i) |=> !ext_ack_o);

  assert_released_follows_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_released_o == ext_ack_o);

  assert_oe_driven_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_released_o |-> (we_oe_o && rd_oe_o));

  assert_oe_float_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_released_o && !cfg_rdata_o[2]) |-> (!we_oe_o && !rd_oe_o));

  assert_reserved_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rdata_o[DATA_W-1:3] == '0);
endmodule

bind lbus_arbiter lbus_arbiter_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .slave_boot_i    (slave_boot_i),
  .cfg_rdata_o     (cfg_rdata_o),
  .ext_req_i       (ext_req_i),
  .ext_ack_o       (ext_ack_o),
  .dma_burst_req_i (dma_burst_req_i),
  .cpu_req_i       (cpu_req_i),
  .dma_req_i       (dma_req_i),
  .pci_req_i       (pci_req_i),
  .grant_o         (grant_o),
  .bus_released_o  (bus_released_o),
  .we_oe_o         (we_oe_o),
  .rd_oe_o         (rd_oe_o)
);

// File: tb/sim_lbus_arbiter.sv
`timescale 1ns/1ps
module sim_lbus_arbiter;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          boot = 1'b0, cfg_we = 1'b0;
  logic [DW-1:0] cfg_wdata = '0;
  logic [DW-1:0] cfg_rdata;
  logic          ext_req = 0, burst = 0, cpu = 0, dma = 0, pci = 0, done = 0;
  logic          ack, released, we_oe, rd_oe;
  logic [4:0]    grant;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int       m_owner;
  logic     m_ack;
  logic [2:0] m_cfg;

  always #2.5 clk = ~clk;

  lbus_arbiter #(.DATA_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .slave_boot_i(boot),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .ext_req_i(ext_req), .ext_ack_o(ack), .dma_burst_req_i(burst),
    .cpu_req_i(cpu), .dma_req_i(dma), .pci_req_i(pci), .xfer_done_i(done),
    .grant_o(grant), .bus_released_o(released), .we_oe_o(we_oe), .rd_oe_o(rd_oe)
  );

  function automatic logic [4:0] req_now(logic [2:0] c);
    return {pci, dma, cpu, burst, ext_req & (c[0] | boot)};
  endfunction

  function automatic int next_owner(int own, logic [2:0] c);
    logic [4:0] r;
    int w;
    logic lock, sw;
    r = req_now(c);
    w = 2;
    for (int i = 4; i >= 0; i--) if (r[i]) w = i;
    lock = c[1] && own == 1 && burst;
    sw = !r[own] || (done && !lock);
    return sw ? w : own;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(string gtag);
    check(gtag, 32'(grant), 32'(1) << m_owner);
    check("R7 ack", 32'(ack), 32'(m_ack));
    check("R7 released", 32'(released), 32'(m_ack));
    check("R8 we_oe", 32'(we_oe), 32'(!m_ack || m_cfg[2]));
    check("R8 rd_oe", 32'(rd_oe), 32'(!m_ack || m_cfg[2]));
    check("R9 rdata", cfg_rdata, {29'd0, m_cfg});
  endtask

  // inputs are set at a falling edge; one rising edge later the outputs are compared
  task automatic step(string gtag);
    int       no;
    logic     na;
    logic [2:0] nc;
    no = next_owner(m_owner, m_cfg);
    na = (m_owner == 0) && (ext_req & (m_cfg[0] | boot));
    nc = cfg_we ? cfg_wdata[2:0] : m_cfg;
    @(posedge clk);
    m_owner = no; m_ack = na; m_cfg = nc;
    @(negedge clk);
    cfg_we = 1'b0;
    check_all(gtag);
  endtask

  task automatic wr_cfg(logic [31:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    step("R9 write");
  endtask

  task automatic set_req(logic e, logic b, logic c, logic d, logic p, logic dn);
    ext_req = e; burst = b; cpu = c; dma = d; pci = p; done = dn;
  endtask

  initial begin
    m_owner = 2; m_ack = 0; m_cfg = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset");

    // reserved bits
    wr_cfg(32'hFFFF_FFF8);
    wr_cfg(32'hFFFF_FFFF);
    wr_cfg(32'h0000_0001);

    // priority chain, lock off (R2)
    set_req(0, 1, 1, 1, 1, 1); step("R2 burst wins");
    set_req(0, 0, 1, 1, 1, 1); step("R2 cpu wins");
    set_req(0, 0, 0, 1, 1, 1); step("R2 dma wins");
    set_req(0, 0, 0, 0, 1, 1); step("R2 pci wins");
    set_req(1, 0, 0, 0, 1, 1); step("R2 ext wins");
    step("R7 ack rises");
    set_req(0, 0, 0, 0, 0, 0); step("R7 req drop");
    step("R1 idle cpu");

    // R3: no preempt without boundary
    set_req(0, 0, 0, 1, 0, 0); step("R3 dma takes idle");
    set_req(0, 0, 1, 1, 0, 0); step("R3 no preempt");
    set_req(0, 0, 1, 1, 0, 1); step("R3 preempt at boundary");

    // R4 lock clear: ext preempts burst at boundary
    set_req(0, 1, 0, 0, 0, 1); step("R4 burst owns");
    set_req(1, 1, 0, 0, 0, 1); step("R4 unlocked preempt");
    set_req(0, 1, 0, 0, 0, 1); step("R4 back to burst");
    // R4 lock set
    wr_cfg(32'h3);
    set_req(1, 1, 0, 0, 0, 1); step("R4 locked hold");
    step("R4 locked hold 2");
    set_req(1, 0, 0, 0, 0, 1); step("R4 burst ends release");
    step("R8 float");
    set_req(0, 0, 0, 0, 0, 0); step("R7 drop");

    // R5 ignore, R6 strap
    wr_cfg(32'h0);
    set_req(1, 0, 0, 0, 0, 1); step("R5 ignored");
    step("R5 ignored 2");
    boot = 1'b1; step("R6 strap accepts");
    step("R6 ack");
    wr_cfg(32'h4);
    step("R8 driven");
    boot = 1'b0; step("R5 acceptance dropped");
    set_req(0, 0, 0, 0, 0, 0); step("R1 idle");

    // seeded random traffic
    void'($urandom(32'd2024));
    for (int k = 0; k < 4000; k++) begin
      string tag;
      set_req($urandom_range(0, 2) == 0, $urandom_range(0, 2) == 0, $urandom_range(0, 1) == 0,
              $urandom_range(0, 2) == 0, $urandom_range(0, 2) == 0, $urandom_range(0, 2) == 0);
      if ($urandom_range(0, 15) == 0) boot = ~boot;
      if ($urandom_range(0, 19) == 0) begin cfg_we = 1'b1; cfg_wdata = $urandom; end
      if (m_cfg[1] && m_owner == 1 && burst) tag = "R4 random";
      else if (ext_req && !m_cfg[0] && !boot) tag = "R5 random";
      else if (ext_req && boot && !m_cfg[0]) tag = "R6 random";
      else tag = "R3 random";
      step(tag);
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule